// File: doc/BRIEF.md
# Switch-Controlled Pong Game Engine

This block plays a two-player paddle-and-ball game on a raster display and paints it into the video stream. It sits downstream of a pixel counter and a pattern source. Each pixel clock it receives the current pixel coordinate, an active-area flag and the pattern colour. One cycle later it returns the colour to show. While the game is disabled the pattern passes through unchanged. While it is enabled the playfield is painted in a background colour, with the paddles and the ball drawn on top.

Each player has one level-sensitive switch. While the switch is on, that player's paddle climbs. While it is off, the paddle sinks. Game state advances only on a one-cycle frame tick, which the timing generator issues on the first line of vertical blanking, so positions never change mid-picture. When the ball gets past a paddle, the other player earns a point and the ball is served again from the centre of the screen. Two binary score counters feed external digit displays. A game reset input restarts the match without disturbing the video path. The active-low global reset clears everything, including the output register.

Paddle length, width and inset from the side edge, paddle step, ball size, ball step, active area size and the three colours are all parameters.

Top module: `pong_engine`

## Requirements
- R1: When `pixActive` is low, `rgbOut` is 12'h000 in the following cycle. `rgbOut` always reflects the pixel inputs of the previous clock cycle.
- R2: While `gameEn` is low, an active pixel shows `patRgb` one cycle later. Frame ticks are ignored, so paddles, ball and scores keep their values.
- R3: While `gameEn` is high, an active pixel shows `BALL_RGB` if it lies inside the ball square. Otherwise it shows `PAD_RGB` if it lies inside either paddle rectangle, and otherwise `BG_RGB`. The left paddle spans x in [PAD_GAP, PAD_GAP+PAD_W). The right paddle spans x in [H_ACTIVE-PAD_GAP-PAD_W, H_ACTIVE-PAD_GAP). Each paddle spans PAD_LEN rows from its top row.
- R4: On an enabled frame tick, each paddle's top row decreases by PAD_SPEED if its switch is 1 and increases by PAD_SPEED if its switch is 0. Without a tick, paddles do not move.
- R5: A paddle top row never goes below 0 or above V_ACTIVE-PAD_LEN; a step that would cross a limit stops exactly at that limit.
- R6: On an enabled tick the ball moves BALL_SPEED on each axis. Moving down, if its top row plus BALL_SPEED reaches V_ACTIVE-BALL_SIZE or more, it is placed at V_ACTIVE-BALL_SIZE and turns up. Moving up, if its top row is at most BALL_SPEED, it is placed at row 0 and turns down.
- R7: A leftward ball whose left column is below PAD_GAP+PAD_W+BALL_SPEED, and whose rows overlap the left paddle's rows, is placed with its left column at PAD_GAP+PAD_W and turns right. The right paddle mirrors this, with the ball's right edge placed at H_ACTIVE-PAD_GAP-PAD_W. The overlap test uses positions from before the tick.
- R8: If that crossing happens without row overlap, the opposite player's score increments. The ball is then served from ((H_ACTIVE-BALL_SIZE)/2, (V_ACTIVE-BALL_SIZE)/2), moving down and horizontally toward the player who scored.
- R9: Each score is a 4-bit binary count that stops at 9.
- R10: `gameRst` high at a clock edge, or `rst_n` low, returns both scores to 0, both paddles to top row (V_ACTIVE-PAD_LEN)/2, and the ball to the serve point moving right and down. `gameRst` wins over a simultaneous frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous global reset |
| gameRst | input | 1 | Synchronous match restart |
| gameEn | input | 1 | Draw and advance the game when high |
| frameTick | input | 1 | One-cycle pulse once per frame |
| leftUp | input | 1 | Left paddle switch, 1 climbs, 0 sinks |
| rightUp | input | 1 | Right paddle switch, 1 climbs, 0 sinks |
| pixActive | input | 1 | Current pixel lies in the active area |
| pixX | input | clog2(H_ACTIVE) | Current pixel column |
| pixY | input | clog2(V_ACTIVE) | Current pixel row |
| patRgb | input | 12 | Pattern colour for the current pixel |
| rgbOut | output | 12 | Colour to display, one cycle later |
| scoreLeft | output | 4 | Left player score, binary 0 to 9 |
| scoreRight | output | 4 | Right player score, binary 0 to 9 |

## Verification
The bench shrinks the block to a 64 by 48 field, with 12-row paddles stepping 3 rows and a 4-pixel ball stepping 2 pixels per axis. At that size a whole frame can be swept pixel by pixel in about three thousand cycles, and each sweep is compared with an arithmetic model of the rules. The small field also makes a single rally take only about thirty ticks. Within 1500 ticks of alternating switch patterns, the run therefore sees many bounces, misses, clamped paddles and saturated scores.

// File: rtl/pong_pkg.sv
package pong_pkg;

  // strobes issued by the control to the datapath, valid for one cycle
  typedef struct packed {
    logic clear;    // restart match
    logic step;     // advance one frame
    logic bounceL;  // ball met left paddle
    logic bounceR;  // ball met right paddle
    logic missL;    // ball got past left paddle
    logic missR;    // ball got past right paddle
  } pong_strobe_t;

  // geometric facts the datapath reports about the current state
  typedef struct packed {
    logic crossL;   // next step would reach the left paddle face
    logic crossR;   // next step would reach the right paddle face
    logic overL;    // ball rows overlap left paddle rows
    logic overR;    // ball rows overlap right paddle rows
  } pong_status_t;

endpackage

// File: rtl/pong_ctrl.sv
module pong_ctrl
  import pong_pkg::*;
(
  input  logic         gameRst,
  input  logic         gameEn,
  input  logic         frameTick,
  input  pong_status_t status,
  output pong_strobe_t strobe
);

  logic stepNow;

  assign stepNow = frameTick && gameEn && !gameRst;

  always_comb begin
    strobe         = '0;
    strobe.clear   = gameRst;
    strobe.step    = stepNow;
    strobe.bounceL = stepNow && status.crossL && status.overL;
    strobe.missL   = stepNow && status.crossL && !status.overL;
    strobe.bounceR = stepNow && status.crossR && status.overR;
    strobe.missR   = stepNow && status.crossR && !status.overR;
  end

endmodule

// File: rtl/pong_dp.sv
module pong_dp
  import pong_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int V_ACTIVE   = 480,
  parameter int PAD_LEN    = 64,
  parameter int PAD_SPEED  = 4,
  parameter int PAD_W      = 8,
  parameter int PAD_GAP    = 16,
  parameter int BALL_SIZE  = 8,
  parameter int BALL_SPEED = 3,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          leftUp,
  input  logic          rightUp,
  input  pong_strobe_t  strobe,
  output pong_status_t  status,
  output logic [XW-1:0] ballX,
  output logic [YW-1:0] ballY,
  output logic [YW-1:0] padL,
  output logic [YW-1:0] padR,
  output logic [3:0]    scoreLeft,
  output logic [3:0]    scoreRight
);

  localparam logic [XW:0]   X_FACE_L = (XW+1)'(PAD_GAP + PAD_W);
  localparam logic [XW:0]   X_FACE_R = (XW+1)'(H_ACTIVE - PAD_GAP - PAD_W);
  localparam logic [XW:0]   X_STEP   = (XW+1)'(BALL_SPEED);
  localparam logic [XW:0]   X_BALL   = (XW+1)'(BALL_SIZE);
  localparam logic [XW-1:0] X_SERVE  = XW'((H_ACTIVE - BALL_SIZE) / 2);
  localparam logic [YW:0]   Y_STEP   = (YW+1)'(BALL_SPEED);
  localparam logic [YW:0]   Y_BALL   = (YW+1)'(BALL_SIZE);
  localparam logic [YW:0]   Y_LEN    = (YW+1)'(PAD_LEN);
  localparam logic [YW:0]   Y_PSTEP  = (YW+1)'(PAD_SPEED);
  localparam logic [YW:0]   Y_BMAX   = (YW+1)'(V_ACTIVE - BALL_SIZE);
  localparam logic [YW:0]   Y_PMAX   = (YW+1)'(V_ACTIVE - PAD_LEN);
  localparam logic [YW-1:0] Y_SERVE  = YW'((V_ACTIVE - BALL_SIZE) / 2);
  localparam logic [YW-1:0] PAD_INIT = YW'((V_ACTIVE - PAD_LEN) / 2);
  localparam logic [3:0]    SCORE_TOP = 4'd9;

  logic        dirRight, dirDown;
  logic [XW:0] bx, xNext;
  logic [YW:0] by, yNext;
  logic        dxNext, dyNext;

  assign bx = {1'b0, ballX};
  assign by = {1'b0, ballY};

  function automatic logic [YW-1:0] movePad(input logic [YW-1:0] p, input logic up);
    logic [YW:0] pe;
    pe = {1'b0, p};
    if (up) movePad = (pe >= Y_PSTEP) ? YW'(pe - Y_PSTEP) : '0;
    else    movePad = (pe + Y_PSTEP <= Y_PMAX) ? YW'(pe + Y_PSTEP) : YW'(Y_PMAX);
  endfunction

  // geometric status toward the control
  always_comb begin
    status.crossL = !dirRight && (bx < X_FACE_L + X_STEP);
    status.crossR = dirRight && (bx + X_STEP + X_BALL > X_FACE_R);
    status.overL  = (by + Y_BALL > {1'b0, padL}) && (by < {1'b0, padL} + Y_LEN);
    status.overR  = (by + Y_BALL > {1'b0, padR}) && (by < {1'b0, padR} + Y_LEN);
  end

  // next ball position: walls on the vertical axis, paddles on the horizontal
  always_comb begin
    if (dirDown) begin
      if (by + Y_STEP >= Y_BMAX) begin yNext = Y_BMAX; dyNext = 1'b0; end
      else                       begin yNext = by + Y_STEP; dyNext = 1'b1; end
    end else begin
      if (by <= Y_STEP) begin yNext = '0; dyNext = 1'b1; end
      else              begin yNext = by - Y_STEP; dyNext = 1'b0; end
    end
    if (strobe.bounceL) begin
      xNext = X_FACE_L; dxNext = 1'b1;
    end else if (strobe.bounceR) begin
      xNext = X_FACE_R - X_BALL; dxNext = 1'b0;
    end else if (dirRight) begin
      xNext = bx + X_STEP; dxNext = 1'b1;
    end else begin
      xNext = bx - X_STEP; dxNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ballX <= X_SERVE; ballY <= Y_SERVE; dirRight <= 1'b1; dirDown <= 1'b1;
      padL <= PAD_INIT; padR <= PAD_INIT;
      scoreLeft <= '0; scoreRight <= '0;
    end else if (strobe.clear) begin
      ballX <= X_SERVE; ballY <= Y_SERVE; dirRight <= 1'b1; dirDown <= 1'b1;
      padL <= PAD_INIT; padR <= PAD_INIT;
      scoreLeft <= '0; scoreRight <= '0;
    end else if (strobe.step) begin
      padL <= movePad(padL, leftUp);
      padR <= movePad(padR, rightUp);
      if (strobe.missL || strobe.missR) begin
        ballX    <= X_SERVE;
        ballY    <= Y_SERVE;
        dirRight <= strobe.missL;
        dirDown  <= 1'b1;
      end else begin
        ballX    <= xNext[XW-1:0];
        ballY    <= yNext[YW-1:0];
        dirRight <= dxNext;
        dirDown  <= dyNext;
      end
      if (strobe.missL && scoreRight != SCORE_TOP) scoreRight <= scoreRight + 4'd1;
      if (strobe.missR && scoreLeft != SCORE_TOP)  scoreLeft  <= scoreLeft + 4'd1;
    end
  end

endmodule

// File: rtl/pong_render.sv
module pong_render #(
  parameter int          H_ACTIVE  = 640,
  parameter int          V_ACTIVE  = 480,
  parameter int          PAD_LEN   = 64,
  parameter int          PAD_W     = 8,
  parameter int          PAD_GAP   = 16,
  parameter int          BALL_SIZE = 8,
  parameter logic [11:0] BALL_RGB  = 12'hFFF,
  parameter logic [11:0] PAD_RGB   = 12'hFF0,
  parameter logic [11:0] BG_RGB    = 12'h001,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gameEn,
  input  logic          pixActive,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic [11:0]   patRgb,
  input  logic [XW-1:0] ballX,
  input  logic [YW-1:0] ballY,
  input  logic [YW-1:0] padL,
  input  logic [YW-1:0] padR,
  output logic [11:0]   rgbOut
);

  localparam logic [XW:0] X_BALL = (XW+1)'(BALL_SIZE);
  localparam logic [YW:0] Y_BALL = (YW+1)'(BALL_SIZE);
  localparam logic [XW:0] X_PW   = (XW+1)'(PAD_W);
  localparam logic [YW:0] Y_LEN  = (YW+1)'(PAD_LEN);

  logic [XW:0]   px;
  logic [YW:0]   py;
  logic          inBall;
  logic [1:0]    inPad;
  logic [YW-1:0] padTop [2];
  logic [11:0]   colour;

  assign px = {1'b0, pixX};
  assign py = {1'b0, pixY};
  assign padTop[0] = padL;
  assign padTop[1] = padR;

  assign inBall = (px >= {1'b0, ballX}) && (px < {1'b0, ballX} + X_BALL) &&
                  (py >= {1'b0, ballY}) && (py < {1'b0, ballY} + Y_BALL);

  for (genvar s = 0; s < 2; s++) begin : g_pad
    localparam logic [XW:0] X0 = (s == 0) ? (XW+1)'(PAD_GAP)
                                          : (XW+1)'(H_ACTIVE - PAD_GAP - PAD_W);
    assign inPad[s] = (px >= X0) && (px < X0 + X_PW) &&
                      (py >= {1'b0, padTop[s]}) && (py < {1'b0, padTop[s]} + Y_LEN);
  end

  always_comb begin
    if (!pixActive)  colour = 12'h000;
    else if (!gameEn) colour = patRgb;
    else if (inBall)  colour = BALL_RGB;
    else if (|inPad)  colour = PAD_RGB;
    else              colour = BG_RGB;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgbOut <= 12'h000;
    else        rgbOut <= colour;
  end

endmodule

// File: rtl/pong_engine.sv
module pong_engine
  import pong_pkg::*;
#(
  parameter int          H_ACTIVE   = 640,
  parameter int          V_ACTIVE   = 480,
  parameter int          PAD_LEN    = 64,
  parameter int          PAD_SPEED  = 4,
  parameter int          PAD_W      = 8,
  parameter int          PAD_GAP    = 16,
  parameter int          BALL_SIZE  = 8,
  parameter int          BALL_SPEED = 3,
  parameter logic [11:0] BALL_RGB   = 12'hFFF,
  parameter logic [11:0] PAD_RGB    = 12'hFF0,
  parameter logic [11:0] BG_RGB     = 12'h001,
  localparam int XW = $clog2(H_ACTIVE),
  localparam int YW = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gameRst,
  input  logic          gameEn,
  input  logic          frameTick,
  input  logic          leftUp,
  input  logic          rightUp,
  input  logic          pixActive,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic [11:0]   patRgb,
  output logic [11:0]   rgbOut,
  output logic [3:0]    scoreLeft,
  output logic [3:0]    scoreRight
);

  pong_strobe_t  strobe;
  pong_status_t  status;
  logic [XW-1:0] ballX;
  logic [YW-1:0] ballY, padL, padR;

  pong_ctrl u_ctrl (
    .gameRst(gameRst), .gameEn(gameEn), .frameTick(frameTick),
    .status(status), .strobe(strobe)
  );

  pong_dp #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .PAD_LEN(PAD_LEN),
    .PAD_SPEED(PAD_SPEED), .PAD_W(PAD_W), .PAD_GAP(PAD_GAP),
    .BALL_SIZE(BALL_SIZE), .BALL_SPEED(BALL_SPEED)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .leftUp(leftUp), .rightUp(rightUp),
    .strobe(strobe), .status(status),
    .ballX(ballX), .ballY(ballY), .padL(padL), .padR(padR),
    .scoreLeft(scoreLeft), .scoreRight(scoreRight)
  );

  pong_render #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .PAD_LEN(PAD_LEN),
    .PAD_W(PAD_W), .PAD_GAP(PAD_GAP), .BALL_SIZE(BALL_SIZE),
    .BALL_RGB(BALL_RGB), .PAD_RGB(PAD_RGB), .BG_RGB(BG_RGB)
  ) u_render (
    .clk(clk), .rst_n(rst_n), .gameEn(gameEn), .pixActive(pixActive),
    .pixX(pixX), .pixY(pixY), .patRgb(patRgb),
    .ballX(ballX), .ballY(ballY), .padL(padL), .padR(padR),
    .rgbOut(rgbOut)
  );

endmodule

// File: rtl/pong_engine_chk.sv
module pong_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gameRst,
  input logic        gameEn,
  input logic        frameTick,
  input logic        pixActive,
  input logic [11:0] patRgb,
  input logic [11:0] rgbOut,
  input logic [3:0]  scoreLeft,
  input logic [3:0]  scoreRight
);

  AST_SCORE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    (scoreLeft <= 4'd9) && (scoreRight <= 4'd9)); // R9

  AST_SCORE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (scoreLeft != $past(scoreLeft) || scoreRight != $past(scoreRight))
      |-> ($past(frameTick) || $past(gameRst))); // R8

  AST_SCORE_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (scoreLeft != $past(scoreLeft))
      |-> (scoreLeft == $past(scoreLeft) + 4'd1 || scoreLeft == 4'd0)); // R8

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    gameRst |=> (scoreLeft == 4'd0 && scoreRight == 4'd0)); // R10

  AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !pixActive |=> rgbOut == 12'h000); // R1

  AST_PATTERN_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pixActive && !gameEn) |=> rgbOut == $past(patRgb)); // R2

endmodule

bind pong_engine pong_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gameRst(gameRst), .gameEn(gameEn),
  .frameTick(frameTick), .pixActive(pixActive), .patRgb(patRgb),
  .rgbOut(rgbOut), .scoreLeft(scoreLeft), .scoreRight(scoreRight)
);

// File: tb/pong_engine_tb.sv
module pong_engine_tb;

  localparam int H = 64, V = 48, LEN = 12, PS = 3, PW = 2, PG = 2, BALL = 4, BS = 2;
  localparam logic [11:0] C_BALL = 12'hFFF, C_PAD = 12'h0F0, C_BG = 12'h008;
  localparam int XW = $clog2(H), YW = $clog2(V);
  localparam int XF = PG + PW, XR = H - PG - PW;
  localparam int CX = (H - BALL) / 2, CY = (V - BALL) / 2, PINIT = (V - LEN) / 2;

  logic clk = 0, rst_n = 0, gameRst = 0, gameEn = 0, frameTick = 0;
  logic leftUp = 0, rightUp = 0, pixActive = 0;
  logic [XW-1:0] pixX = '0;
  logic [YW-1:0] pixY = '0;
  logic [11:0] patRgb = '0;
  logic [11:0] rgbOut;
  logic [3:0] scoreLeft, scoreRight;

  int checks = 0, errors = 0;
  int mBx, mBy, mDx, mDy, mPl, mPr, mSl, mSr;

  always #4 clk = ~clk;

  pong_engine #(
    .H_ACTIVE(H), .V_ACTIVE(V), .PAD_LEN(LEN), .PAD_SPEED(PS), .PAD_W(PW),
    .PAD_GAP(PG), .BALL_SIZE(BALL), .BALL_SPEED(BS),
    .BALL_RGB(C_BALL), .PAD_RGB(C_PAD), .BG_RGB(C_BG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .gameRst(gameRst), .gameEn(gameEn),
    .frameTick(frameTick), .leftUp(leftUp), .rightUp(rightUp),
    .pixActive(pixActive), .pixX(pixX), .pixY(pixY), .patRgb(patRgb),
    .rgbOut(rgbOut), .scoreLeft(scoreLeft), .scoreRight(scoreRight)
  );

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  task automatic modelReset();
    mBx = CX; mBy = CY; mDx = 1; mDy = 1; mPl = PINIT; mPr = PINIT; mSl = 0; mSr = 0;
  endtask

  function automatic int padMove(input int p, input logic up);
    if (up) return (p >= PS) ? p - PS : 0;
    return (p + PS <= V - LEN) ? p + PS : V - LEN;
  endfunction

  task automatic modelStep(input logic lu, input logic ru);
    int ny, ndy, nx, ndx;
    bit crossL, crossR, ovL, ovR;
    crossL = (mDx == 0) && (mBx < XF + BS);
    crossR = (mDx == 1) && (mBx + BS + BALL > XR);
    ovL = (mBy + BALL > mPl) && (mBy < mPl + LEN);
    ovR = (mBy + BALL > mPr) && (mBy < mPr + LEN);
    if (mDy == 1) begin
      if (mBy + BS >= V - BALL) begin ny = V - BALL; ndy = 0; end
      else begin ny = mBy + BS; ndy = 1; end
    end else begin
      if (mBy <= BS) begin ny = 0; ndy = 1; end
      else begin ny = mBy - BS; ndy = 0; end
    end
    if (mDx == 1) nx = mBx + BS; else nx = mBx - BS;
    ndx = mDx;
    if (crossL && ovL) begin nx = XF; ndx = 1; end
    else if (crossR && ovR) begin nx = XR - BALL; ndx = 0; end
    else if (crossL) begin
      if (mSr < 9) mSr++;
      nx = CX; ny = CY; ndx = 1; ndy = 1;
    end else if (crossR) begin
      if (mSl < 9) mSl++;
      nx = CX; ny = CY; ndx = 0; ndy = 1;
    end
    mBx = nx; mBy = ny; mDx = ndx; mDy = ndy;
    mPl = padMove(mPl, lu); mPr = padMove(mPr, ru);
  endtask

  function automatic logic [11:0] expPix(input int x, input int y, input logic act,
                                         input logic en, input logic [11:0] pat);
    if (!act) return 12'h000;
    if (!en) return pat;
    if (x >= mBx && x < mBx + BALL && y >= mBy && y < mBy + BALL) return C_BALL;
    if (x >= PG && x < PG + PW && y >= mPl && y < mPl + LEN) return C_PAD;
    if (x >= XR && x < XR + PW && y >= mPr && y < mPr + LEN) return C_PAD;
    return C_BG;
  endfunction

  // sweeps every pixel of the field; output is compared one cycle after drive
  task automatic scan(input string tag);
    int bad = 0, fx = 0, fy = 0;
    logic have = 0;
    logic [11:0] expQ = '0, gotF = '0, expF = '0;
    int px = 0, py = 0;
    for (int y = 0; y < V; y++) begin
      for (int x = 0; x < H; x++) begin
        @(negedge clk);
        if (have && rgbOut !== expQ) begin
          if (bad == 0) begin fx = px; fy = py; gotF = rgbOut; expF = expQ; end
          bad++;
        end
        pixX = XW'(x); pixY = YW'(y);
        pixActive = ((x + y) % 13) != 0;
        patRgb = 12'(x * 37 + y * 101);
        expQ = expPix(x, y, pixActive, gameEn, patRgb);
        px = x; py = y; have = 1;
      end
    end
    @(negedge clk);
    if (rgbOut !== expQ) begin
      if (bad == 0) begin fx = px; fy = py; gotF = rgbOut; expF = expQ; end
      bad++;
    end
    pixActive = 0;
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: %0d pixel mismatches, first at (%0d,%0d) actual=%h expected=%h",
               tag, bad, fx, fy, gotF, expF);
    end
  endtask

  task automatic checkScores(input string tag);
    checks++;
    if (scoreLeft !== 4'(mSl) || scoreRight !== 4'(mSr)) begin
      errors++;
      $display("FAIL %s: scores actual=%0d/%0d expected=%0d/%0d",
               tag, scoreLeft, scoreRight, mSl, mSr);
    end
  endtask

  task automatic tick(input logic lu, input logic ru);
    @(negedge clk);
    leftUp = lu; rightUp = ru; frameTick = 1;
    if (gameEn && !gameRst) modelStep(lu, ru);
    @(negedge clk);
    frameTick = 0;
  endtask

  initial begin
    modelReset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checkScores("R10 global reset");

    // disabled: pattern passes, blanking outside active (R1, R2)
    gameEn = 0;
    scan("R1 R2 disabled pattern passthrough");
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    checkScores("R2 ticks ignored while disabled");

    // enabled at initial state (R2 frozen, R3, R10)
    gameEn = 1;
    scan("R2 R3 R10 initial frame after frozen ticks");

    tick(1'b1, 1'b0);
    scan("R4 R6 first step");

    // drive paddles into both limits (R5)
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0);
    scan("R5 R6 clamped paddles");
    checkScores("R8 after clamp run");

    // long rally sweep: bounces, misses, serves, saturation
    for (int t = 0; t < 1500; t++) begin
      tick(((t / 7) % 2) == 1, ((t / 11) % 3) == 0);
      checkScores("R8 R9 score per tick");
      if ((t % 60) == 59) scan("R3 R4 R5 R6 R7 R8 rally frame");
    end
    checks++;
    if (scoreLeft !== 4'(mSl) || (mSl == 9 && scoreLeft !== 4'd9)) begin
      errors++;
      $display("FAIL R9 saturation: actual=%0d expected=%0d", scoreLeft, mSl);
    end

    // restart together with a tick: restart wins (R10)
    @(negedge clk);
    gameRst = 1; frameTick = 1;
    @(negedge clk);
    gameRst = 0; frameTick = 0;
    modelReset();
    checkScores("R10 game restart");
    scan("R10 restart frame");

    finishRun();
  end

endmodule